// File: doc/BRIEF.md
# Multi-rate lock search controller

This block is the digital sequencer that sits beside the analog loop of a multi-rate serial reclocker. It runs in the reference clock domain. It measures the frequency of the divided VCO by counting its pulses over a fixed number of reference cycles, and compares that count with the count expected at the nominal rate. It chooses which divider ratio the loop uses. It also decides whether the loop is in frequency acquisition or in phase tracking, and it reports which rate was last acquired.

In automatic mode the block tries each supported rate in turn. It stays on each rate for a programmable number of measurement windows, then moves to the next rate in the fixed sequence 270, 2970, 1485 Mb/s and wraps back to the start. In manual mode the rate comes from a 3-bit code input, and the block tries only that rate. Hysteresis keeps the lock stable: the count must be within 1% of nominal to acquire lock, and lock is released only when the error exceeds 2%. After lock is released, the divider stays on the last rate, so an interrupted signal at the same rate is acquired again at once.

Top module: `rate_lock_ctrl`

## Requirements
- R1: While rst_n is low, and on the first cycle after it is released, locked and phase_mode are 0, div_sel is 0 and rate_code_out is 3'b010.
- R2: Rate codes map to divider indices as follows: 3'b010 (270 Mb/s) is index 0, 3'b110 (2970 Mb/s) is index 1, and 3'b101 (1485 Mb/s) is index 2. div_sel outputs the index currently in use, and rate_code_out outputs the code of an index.
- R3: A measurement window is WINDOW consecutive reference cycles, counted freely from the release of reset. At the end of a window during acquisition, locked and phase_mode are set in the next cycle if |count − NOMINAL| ≤ floor(NOMINAL·ACQ_PCT/100). Otherwise they stay 0.
- R4: While locked, the lock is kept at the end of any window where |count − NOMINAL| ≤ floor(NOMINAL·REL_PCT/100). A larger error, including a count of zero, clears locked and phase_mode and leaves div_sel unchanged.
- R5: In automatic mode, div_sel advances in the order 0 → 1 → 2 → 0 after DWELL consecutive windows that end without lock. div_sel changes only at the end of a window.
- R6: After lock is released, the dwell count restarts on the same index. A matching window within the dwell therefore acquires lock again at the same rate.
- R7: rate_code_out takes the code of div_sel when lock is acquired, and it holds that value while the loop is unlocked.
- R8: In manual mode with a valid code, div_sel follows the decoded code from the next cycle on and never advances. Lock is acquired only at that index.
- R9: In manual mode, a code outside the three valid codes forces locked and phase_mode to 0 from the next cycle and leaves div_sel where it was.
- R10: In manual mode, a change to a valid code whose index differs from div_sel clears the lock in the next cycle.
- R11: In automatic mode, rate_code_in has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; also times the measurement windows |
| rst_n | input | 1 | Active-low synchronous reset |
| auto_mode | input | 1 | 1 selects the automatic search, 0 selects the forced rate |
| rate_code_in | input | 3 | Forced rate code, used in manual mode |
| vco_tick | input | 1 | One-cycle pulse per divided-VCO period, synchronous to ref_clk |
| div_sel | output | 2 | Divider ratio index in use |
| phase_mode | output | 1 | 1 = phase tracking, 0 = frequency acquisition |
| locked | output | 1 | Lock indication |
| rate_code_out | output | 3 | Code of the last rate acquired |

## Verification
The bench builds the block with WINDOW = 256, NOMINAL = 200 and DWELL = 2. With these values the acquire tolerance is 2 counts and the release tolerance is 4 counts. Both hysteresis edges can then be hit exactly: offsets of ±2 and +3 test the acquire edge, and +4 and +5 test the release edge. The short dwell makes a full wrap of the search sequence, through every rate, take only a few windows. A bench model of the VCO emits the nominal count only when div_sel matches the rate the bench has chosen as present. This lets the bench observe search order, relock to the same rate, manual forcing and the rejection of invalid codes at the ports.

// File: rtl/rl_pkg.sv
package rl_pkg;
    localparam int NUM_RATES = 3;

    localparam logic [2:0] CODE_SD  = 3'b010;
    localparam logic [2:0] CODE_3G  = 3'b110;
    localparam logic [2:0] CODE_HD  = 3'b101;

    function automatic logic rl_code_valid(input logic [2:0] code);
        return (code == CODE_SD) || (code == CODE_3G) || (code == CODE_HD);
    endfunction

    function automatic logic [1:0] rl_code_to_idx(input logic [2:0] code);
        case (code)
            CODE_3G: return 2'd1;
            CODE_HD: return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic [2:0] rl_idx_to_code(input logic [1:0] idx);
        case (idx)
            2'd1:    return CODE_3G;
            2'd2:    return CODE_HD;
            default: return CODE_SD;
        endcase
    endfunction

    function automatic logic [1:0] rl_next_idx(input logic [1:0] idx);
        return (int'(idx) >= NUM_RATES - 1) ? 2'd0 : idx + 2'd1;
    endfunction
endpackage

// File: rtl/rl_win_meter.sv
module rl_win_meter #(
    parameter int WINDOW = 1024,
    localparam int CW = $clog2(WINDOW + 1),
    localparam int WW = $clog2(WINDOW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          clr,
    output logic          win_done,
    output logic [CW-1:0] total
);
    logic [WW-1:0] win_d, win_q;
    logic [CW-1:0] cnt_d, cnt_q;

    assign win_done = (win_q == WW'(WINDOW - 1));
    assign total    = cnt_q + CW'(tick);

    always_comb begin
        win_d = win_done ? '0 : win_q + 1'b1;
        if (win_done)
            cnt_d = '0;
        else if (clr)
            cnt_d = CW'(tick);
        else
            cnt_d = total;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
            cnt_q <= '0;
        end else begin
            win_q <= win_d;
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/rl_seq_fsm.sv
module rl_seq_fsm
    import rl_pkg::*;
#(
    parameter int CW = 11,
    parameter int NOMINAL = 512,
    parameter int ACQ_TOL = 5,
    parameter int REL_TOL = 10,
    parameter int DWELL = 4,
    localparam int DW = $clog2(DWELL + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          auto_mode,
    input  logic [2:0]    rate_code_in,
    input  logic          win_done,
    input  logic [CW-1:0] total,
    output logic          meter_clr,
    output logic          lock_o,
    output logic [1:0]    idx_o,
    output logic [1:0]    last_o
);
    typedef struct packed {
        logic          locked;
        logic [1:0]    idx;
        logic [1:0]    last;
        logic [DW-1:0] dwell;
    } seq_t;

    localparam logic [CW-1:0] NOM_C = CW'(NOMINAL);

    seq_t          st_d, st_q;
    logic [CW-1:0] dev;
    logic          man_ok;
    logic [1:0]    man_idx;

    assign dev     = (total >= NOM_C) ? total - NOM_C : NOM_C - total;
    assign man_ok  = rl_code_valid(rate_code_in);
    assign man_idx = rl_code_to_idx(rate_code_in);

    always_comb begin
        st_d      = st_q;
        meter_clr = 1'b0;
        if (!auto_mode && !man_ok) begin
            st_d.locked = 1'b0;
            st_d.dwell  = '0;
        end else if (!auto_mode && man_idx != st_q.idx) begin
            st_d.idx    = man_idx;
            st_d.locked = 1'b0;
            st_d.dwell  = '0;
            meter_clr   = 1'b1;
        end else if (win_done) begin
            if (st_q.locked) begin
                if (dev > CW'(REL_TOL)) begin
                    st_d.locked = 1'b0;
                    st_d.dwell  = '0;
                end
            end else if (dev <= CW'(ACQ_TOL)) begin
                st_d.locked = 1'b1;
                st_d.last   = st_q.idx;
                st_d.dwell  = '0;
            end else if (auto_mode) begin
                if (st_q.dwell >= DW'(DWELL - 1)) begin
                    st_d.idx   = rl_next_idx(st_q.idx);
                    st_d.dwell = '0;
                end else begin
                    st_d.dwell = st_q.dwell + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '{locked: 1'b0, idx: 2'd0, last: 2'd0, dwell: '0};
        else
            st_q <= st_d;
    end

    assign lock_o = st_q.locked;
    assign idx_o  = st_q.idx;
    assign last_o = st_q.last;
endmodule

// File: rtl/rate_lock_ctrl.sv
module rate_lock_ctrl
    import rl_pkg::*;
#(
    parameter int WINDOW  = 1024,
    parameter int NOMINAL = 512,
    parameter int DWELL   = 4,
    parameter int ACQ_PCT = 1,
    parameter int REL_PCT = 2
) (
    input  logic       ref_clk,
    input  logic       rst_n,
    input  logic       auto_mode,
    input  logic [2:0] rate_code_in,
    input  logic       vco_tick,
    output logic [1:0] div_sel,
    output logic       phase_mode,
    output logic       locked,
    output logic [2:0] rate_code_out
);
    localparam int CW      = $clog2(WINDOW + 1);
    localparam int ACQ_TOL = NOMINAL * ACQ_PCT / 100;
    localparam int REL_TOL = NOMINAL * REL_PCT / 100;

    logic          win_done;
    logic          meter_clr;
    logic [CW-1:0] total;
    logic          lock_w;
    logic [1:0]    idx_w;
    logic [1:0]    last_w;

    rl_win_meter #(.WINDOW(WINDOW)) meter_i (
        .clk      (ref_clk),
        .rst_n    (rst_n),
        .tick     (vco_tick),
        .clr      (meter_clr),
        .win_done (win_done),
        .total    (total)
    );

    rl_seq_fsm #(
        .CW(CW), .NOMINAL(NOMINAL), .ACQ_TOL(ACQ_TOL),
        .REL_TOL(REL_TOL), .DWELL(DWELL)
    ) fsm_i (
        .clk          (ref_clk),
        .rst_n        (rst_n),
        .auto_mode    (auto_mode),
        .rate_code_in (rate_code_in),
        .win_done     (win_done),
        .total        (total),
        .meter_clr    (meter_clr),
        .lock_o       (lock_w),
        .idx_o        (idx_w),
        .last_o       (last_w)
    );

    assign div_sel       = idx_w;
    assign locked        = lock_w;
    assign phase_mode    = lock_w;
    assign rate_code_out = rl_idx_to_code(last_w);
endmodule

// File: rtl/rl_ctrl_chk.sv
module rl_ctrl_chk
    import rl_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       auto_mode,
    input logic [2:0] rate_code_in,
    input logic       win_done,
    input logic       locked,
    input logic [1:0] div_sel,
    input logic [2:0] rate_code_out
);
    // R9
    invalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_mode && !rl_code_valid(rate_code_in)) |=> !locked);

    // R5
    search_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode && !win_done) |=> $stable(div_sel));

    // R3
    lock_at_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(win_done));

    // R4
    drop_at_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(locked) && $past(auto_mode)) |-> $past(win_done));

    // R8
    manual_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_mode && rl_code_valid(rate_code_in))
        |=> (div_sel == rl_code_to_idx($past(rate_code_in))));

    // R7
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |=> (locked || $stable(rate_code_out)));

    // R2
    code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rl_code_valid(rate_code_out));
endmodule

bind rate_lock_ctrl rl_ctrl_chk chk_i (
    .clk           (ref_clk),
    .rst_n         (rst_n),
    .auto_mode     (auto_mode),
    .rate_code_in  (rate_code_in),
    .win_done      (win_done),
    .locked        (locked),
    .div_sel       (div_sel),
    .rate_code_out (rate_code_out)
);

// File: tb/rate_lock_ctrl_tb_top.sv
module rate_lock_ctrl_tb_top;
    localparam int WIN = 256;
    localparam int NOM = 200;
    localparam int DWL = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       auto_mode = 1'b1;
    logic [2:0] rate_code_in = 3'b000;
    logic       vco_tick = 1'b0;
    logic [1:0] div_sel;
    logic       phase_mode;
    logic       locked;
    logic [2:0] rate_code_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int true_rate = 3;
    int cur_off = 0;

    always #4 clk = ~clk;

    rate_lock_ctrl #(.WINDOW(WIN), .NOMINAL(NOM), .DWELL(DWL)) dut_i (
        .ref_clk(clk), .rst_n(rst_n), .auto_mode(auto_mode),
        .rate_code_in(rate_code_in), .vco_tick(vco_tick), .div_sel(div_sel),
        .phase_mode(phase_mode), .locked(locked), .rate_code_out(rate_code_out)
    );

    typedef struct packed {
        logic              am;
        logic [2:0]        code;
        logic [1:0]        tr;
        logic signed [7:0] off;
        logic [3:0]        nwin;
        logic              lk;
        logic [1:0]        dv;
        logic [2:0]        co;
        logic [3:0]        req;
    } vec_t;

    // Index 0 = 270 (010), 1 = 2970 (110), 2 = 1485 (101); tr 3 = no signal.
    localparam vec_t VECS [18] = '{
        '{1'b1, 3'b000, 2'd2,  8'sd0, 4'd4, 1'b0, 2'd2, 3'b010, 4'd5},  // R5 0->1->2
        '{1'b1, 3'b000, 2'd2,  8'sd0, 4'd1, 1'b1, 2'd2, 3'b101, 4'd3},  // R3 acquire
        '{1'b1, 3'b000, 2'd2,  8'sd4, 4'd1, 1'b1, 2'd2, 3'b101, 4'd4},  // R4 hold at edge
        '{1'b1, 3'b000, 2'd2,  8'sd5, 4'd1, 1'b0, 2'd2, 3'b101, 4'd4},  // R4 release
        '{1'b1, 3'b000, 2'd2,  8'sd3, 4'd1, 1'b0, 2'd2, 3'b101, 4'd3},  // R3 no acquire
        '{1'b1, 3'b000, 2'd2, -8'sd2, 4'd1, 1'b1, 2'd2, 3'b101, 4'd6},  // R6 relock
        '{1'b1, 3'b000, 2'd1,  8'sd0, 4'd1, 1'b0, 2'd2, 3'b101, 4'd4},  // R4 far error
        '{1'b1, 3'b000, 2'd1,  8'sd0, 4'd4, 1'b0, 2'd1, 3'b101, 4'd5},  // R5 wrap 2->0->1
        '{1'b1, 3'b000, 2'd1,  8'sd0, 4'd1, 1'b1, 2'd1, 3'b110, 4'd2},  // R2
        '{1'b1, 3'b000, 2'd0,  8'sd0, 4'd1, 1'b0, 2'd1, 3'b110, 4'd7},  // R7 hold code
        '{1'b1, 3'b000, 2'd0,  8'sd0, 4'd4, 1'b0, 2'd0, 3'b110, 4'd5},  // R5 1->2->0
        '{1'b1, 3'b000, 2'd0,  8'sd0, 4'd1, 1'b1, 2'd0, 3'b010, 4'd2},  // R2
        '{1'b0, 3'b101, 2'd0,  8'sd0, 4'd3, 1'b0, 2'd2, 3'b010, 4'd8},  // R8 no advance
        '{1'b0, 3'b101, 2'd2,  8'sd0, 4'd1, 1'b1, 2'd2, 3'b101, 4'd8},  // R8 lock
        '{1'b0, 3'b000, 2'd2,  8'sd0, 4'd2, 1'b0, 2'd2, 3'b101, 4'd9},  // R9
        '{1'b0, 3'b111, 2'd2,  8'sd0, 4'd1, 1'b0, 2'd2, 3'b101, 4'd9},  // R9
        '{1'b1, 3'b110, 2'd2,  8'sd0, 4'd1, 1'b1, 2'd2, 3'b101, 4'd11}, // R11
        '{1'b1, 3'b110, 2'd3,  8'sd0, 4'd1, 1'b0, 2'd2, 3'b101, 4'd4}   // R4 no pulses
    };

    task automatic chk(input int act, input int exp, input string tag, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int model_count();
        if (true_rate == 3) return 0;
        if (int'(div_sel) == true_rate) return NOM + cur_off;
        return NOM / 2;
    endfunction

    task automatic run_window();
        for (int i = 0; i < WIN; i++) begin
            vco_tick = (i < model_count());
            @(negedge clk);
        end
        vco_tick = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(int'(locked), 0, "R1", "locked");
        chk(int'(phase_mode), 0, "R1", "phase_mode");
        chk(int'(div_sel), 0, "R1", "div_sel");
        chk(int'(rate_code_out), 3'b010, "R1", "rate_code_out");
        rst_n = 1'b1;

        foreach (VECS[n]) begin
            vec_t v;
            string tag;
            v = VECS[n];
            tag = $sformatf("R%0d vec%0d", v.req, n);
            auto_mode    = v.am;
            rate_code_in = v.code;
            true_rate    = int'(v.tr);
            cur_off      = v.off;
            for (int w = 0; w < int'(v.nwin); w++) run_window();
            chk(int'(locked), int'(v.lk), tag, "locked");
            chk(int'(phase_mode), int'(v.lk), tag, "phase_mode");
            chk(int'(div_sel), int'(v.dv), tag, "div_sel");
            chk(int'(rate_code_out), int'(v.co), tag, "rate_code_out");
        end

        // R8 then R10: lock in manual at 1485, then force 2970
        auto_mode    = 1'b0;
        rate_code_in = 3'b101;
        true_rate    = 2;
        cur_off      = 0;
        run_window();
        chk(int'(locked), 1, "R8", "manual locked");
        rate_code_in = 3'b110;
        @(negedge clk);
        chk(int'(locked), 0, "R10", "locked after change");
        chk(int'(phase_mode), 0, "R10", "phase_mode after change");
        chk(int'(div_sel), 1, "R10", "div_sel after change");
        chk(int'(rate_code_out), 3'b101, "R10", "rate_code_out after change");

        finish_run();
    end
endmodule